// File: doc/BRIEF.md
# Stack and Interrupt Micro-Sequencer

This block is the control sequencer that carries out the multi-step stack and string operations of a 16-bit processor: relative CALL, RET, PUSH, POP, STOS and software INT. An instruction is handed over on the issue port with its operation code, register index, immediate and word-size bit. The sequencer then walks a short microprogram held in a computed ROM. Each micro-word selects the ALU operands, the ALU operation, where the result goes (a register, the program counter, an internal parameter latch or a memory word), a side action (load an immediate, or read memory), and the micro-address of the following step.

The block owns the program counter and an eight-entry register file that includes the accumulator, the stack pointer and the destination index. It talks to memory through a byte-addressed word port. Writes take one clock. Reads stall the sequencer until the memory raises its ready signal. For INT, the memory address comes from the ALU instead of from a register, so the vector table entry can be located from the scaled interrupt number.

Top module: `useq_stack_seq`

## Requirements
- R1: After reset the program counter reads 0xFFF0, the stack pointer reads SP_INIT (default 0x0400), `busy` is low, and neither `mem_we` nor `mem_re` is asserted.
- R2: While idle, an issue is accepted only for codes 1 CALL, 2 RET, 3 STOS, 4 PUSH, 5 POP and 6 INT. Codes 0 and 7 leave `busy` low and change nothing. An issue presented while `busy` is high is ignored.
- R3: CALL takes 3 cycles. The stack pointer drops by 2, then the old PC is written as a word at the new stack pointer, then PC becomes old PC plus the 16-bit immediate, modulo 2^16.
- R4: RET reads the word at the stack pointer and loads it into PC in the cycle the memory is ready. The next cycle adds 2 to the stack pointer. The total is 2 cycles plus the read wait.
- R5: PUSH takes 2 cycles. The stack pointer drops by 2, then the register chosen by `issue_reg` is written at the new stack pointer. Index 0 is AX, 4 is SP and 7 is DI; for index 4 the decremented value is written.
- R6: POP reads the word at the stack pointer into the register chosen by `issue_reg`, then adds 2 to the stack pointer. The total is 2 cycles plus the read wait.
- R7: STOS takes 2 cycles. AX is written at the address held in DI with `mem_wide` high whatever `issue_wide` is, then DI grows by 2.
- R8: INT takes 5 cycles plus the read wait. The stack pointer drops by 2. The old PC is written at the new stack pointer. The vector word is read at VEC_BASE + 2 × `issue_imm[7:0]` (upper immediate bits are ignored), and PC becomes the word read.
- R9: While a read is pending without `mem_ready`, PC, the stack pointer, the micro-step and the read address all hold.
- R10: For every step except the STOS store, `mem_wide` follows the `issue_wide` value captured at issue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_valid | input | 1 | Request to start an operation |
| issue_op | input | 3 | Operation code (see R2) |
| issue_reg | input | 3 | Register index for PUSH and POP |
| issue_imm | input | 16 | Call offset, or interrupt number in bits 7:0 |
| issue_wide | input | 1 | Word-size bit of the instruction |
| busy | output | 1 | High while a microprogram runs |
| pc_out | output | 16 | Program counter |
| sp_out | output | 16 | Stack pointer |
| mem_addr | output | 16 | Byte address of the memory access |
| mem_wdata | output | 16 | Write data |
| mem_we | output | 1 | Write strobe, one cycle per write |
| mem_re | output | 1 | Read request, held until ready |
| mem_wide | output | 1 | Word-size bit of the access |
| mem_rdata | input | 16 | Read data, valid with ready |
| mem_ready | input | 1 | Read completes in this cycle |

## Verification
The two functions that can fall in the same cycle are a memory read stall and a new issue request. While RET or POP waits on a slow read, the bench keeps `issue_valid` high with a CALL code, and releases it in the cycle the read completes. The result is judged at the ports. PC and the stack pointer must equal the model's values for the read operation alone, the step count must be exactly 2 plus the wait, no write strobe may appear, and `busy` must fall without a CALL having started.

// File: rtl/useq_pkg.sv
`timescale 1ns/1ps
package useq_pkg;

    localparam int unsigned WORD_W = 16;
    localparam int unsigned UA_W   = 5;
    localparam int unsigned RIDX_W = 3;
    localparam int unsigned N_REGS = 2 ** RIDX_W;

    localparam logic [RIDX_W-1:0] RI_AX = 3'd0;
    localparam logic [RIDX_W-1:0] RI_SP = 3'd4;
    localparam logic [RIDX_W-1:0] RI_DI = 3'd7;

    typedef enum logic [2:0] {
        OP_NONE = 3'd0, OP_CALL = 3'd1, OP_RET = 3'd2, OP_STOS = 3'd3,
        OP_PUSH = 3'd4, OP_POP  = 3'd5, OP_INT = 3'd6, OP_BAD  = 3'd7
    } iop_e;

    typedef enum logic [2:0] {
        NX_EXEC = 3'b000, NX_LD16 = 3'b001, NX_LD8 = 3'b010,
        NX_RD_REG = 3'b011, NX_RD_ALU = 3'b100
    } nxs_e;

    typedef enum logic [2:0] {
        A_ZERO, A_PARAM, A_SP, A_DI, A_PC
    } asel_e;

    typedef enum logic [2:0] {
        B_TWO, B_PC, B_REG, B_AX, B_RDATA, B_LATCH, B_BASE, B_ZERO
    } bsel_e;

    typedef enum logic [2:0] {
        ALU_ADD = 3'b000, ALU_SUB = 3'b001, ALU_SHL = 3'b111
    } aluop_e;

    typedef enum logic [2:0] {
        D_NONE, D_REG, D_SP, D_DI, D_PC, D_MEM, D_PARAM
    } dst_e;

    typedef enum logic {M_SP, M_DI} mreg_e;

    typedef struct packed {
        logic            mas;   // 0: address from register, 1: from ALU
        logic [1:0]      wbo;   // {forced value, force enable}
        asel_e           a;
        bsel_e           b;
        aluop_e          op;
        dst_e            dst;
        mreg_e           mreg;
        nxs_e            nxs;
        logic [UA_W-1:0] nxt;
    } uins_t;

    function automatic uins_t mk(logic mas, logic [1:0] wbo, asel_e a, bsel_e b,
                                 aluop_e op, dst_e d, mreg_e m, nxs_e n,
                                 logic [UA_W-1:0] nx);
        uins_t u;
        u.mas  = mas;
        u.wbo  = wbo;
        u.a    = a;
        u.b    = b;
        u.op   = op;
        u.dst  = d;
        u.mreg = m;
        u.nxs  = n;
        u.nxt  = nx;
        return u;
    endfunction

    // Microprogram start addresses; order of these is fixed by the ROM layout.
    function automatic logic [UA_W-1:0] entry_of(iop_e op);
        case (op)
            OP_CALL: return 5'd1;
            OP_RET:  return 5'd4;
            OP_STOS: return 5'd6;
            OP_PUSH: return 5'd8;
            OP_POP:  return 5'd10;
            OP_INT:  return 5'd12;
            default: return 5'd0;
        endcase
    endfunction

    function automatic uins_t ucode(logic [UA_W-1:0] addr);
        case (addr)
            // relative call
            5'd1:  return mk(1'b0, 2'b00, A_SP,    B_TWO,   ALU_SUB, D_SP,    M_SP, NX_LD16,   5'd2);
            5'd2:  return mk(1'b0, 2'b00, A_ZERO,  B_PC,    ALU_ADD, D_MEM,   M_SP, NX_EXEC,   5'd3);
            5'd3:  return mk(1'b0, 2'b00, A_PARAM, B_PC,    ALU_ADD, D_PC,    M_SP, NX_EXEC,   5'd0);
            // return
            5'd4:  return mk(1'b0, 2'b00, A_ZERO,  B_RDATA, ALU_ADD, D_PC,    M_SP, NX_RD_REG, 5'd5);
            5'd5:  return mk(1'b0, 2'b00, A_SP,    B_TWO,   ALU_ADD, D_SP,    M_SP, NX_EXEC,   5'd0);
            // string store
            5'd6:  return mk(1'b0, 2'b11, A_ZERO,  B_AX,    ALU_ADD, D_MEM,   M_DI, NX_EXEC,   5'd7);
            5'd7:  return mk(1'b0, 2'b00, A_DI,    B_TWO,   ALU_ADD, D_DI,    M_DI, NX_EXEC,   5'd0);
            // push
            5'd8:  return mk(1'b0, 2'b00, A_SP,    B_TWO,   ALU_SUB, D_SP,    M_SP, NX_EXEC,   5'd9);
            5'd9:  return mk(1'b0, 2'b00, A_ZERO,  B_REG,   ALU_ADD, D_MEM,   M_SP, NX_EXEC,   5'd0);
            // pop
            5'd10: return mk(1'b0, 2'b00, A_ZERO,  B_RDATA, ALU_ADD, D_REG,   M_SP, NX_RD_REG, 5'd11);
            5'd11: return mk(1'b0, 2'b00, A_SP,    B_TWO,   ALU_ADD, D_SP,    M_SP, NX_EXEC,   5'd0);
            // software interrupt
            5'd12: return mk(1'b0, 2'b00, A_SP,    B_TWO,   ALU_SUB, D_SP,    M_SP, NX_LD8,    5'd13);
            5'd13: return mk(1'b0, 2'b00, A_ZERO,  B_PC,    ALU_ADD, D_MEM,   M_SP, NX_EXEC,   5'd14);
            5'd14: return mk(1'b0, 2'b00, A_PARAM, B_ZERO,  ALU_SHL, D_PARAM, M_SP, NX_EXEC,   5'd15);
            5'd15: return mk(1'b1, 2'b00, A_PARAM, B_BASE,  ALU_ADD, D_NONE,  M_SP, NX_RD_ALU, 5'd16);
            5'd16: return mk(1'b0, 2'b00, A_ZERO,  B_LATCH, ALU_ADD, D_PC,    M_SP, NX_EXEC,   5'd0);
            default: return mk(1'b0, 2'b00, A_ZERO, B_ZERO, ALU_ADD, D_NONE,  M_SP, NX_EXEC,   5'd0);
        endcase
    endfunction

endpackage

// File: rtl/useq_rom.sv
`timescale 1ns/1ps
module useq_rom
    import useq_pkg::*;
(
    input  logic [UA_W-1:0] addr,
    output uins_t           word
);
    always_comb word = ucode(addr);
endmodule

// File: rtl/useq_alu.sv
`timescale 1ns/1ps
module useq_alu
    import useq_pkg::*;
#(
    parameter int unsigned W = WORD_W
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  aluop_e       op,
    output logic [W-1:0] y
);
    always_comb begin
        case (op)
            ALU_SUB: y = a - b;
            ALU_SHL: y = {a[W-2:0], 1'b0};
            default: y = a + b;
        endcase
    end
endmodule

// File: rtl/useq_regfile.sv
`timescale 1ns/1ps
module useq_regfile
    import useq_pkg::*;
#(
    parameter int unsigned W       = WORD_W,
    parameter logic [W-1:0] SP_INIT = 16'h0400
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [RIDX_W-1:0] widx,
    input  logic [W-1:0]      wdata,
    input  logic [RIDX_W-1:0] ridx,
    output logic [W-1:0]      rdata,
    output logic [W-1:0]      ax,
    output logic [W-1:0]      sp,
    output logic [W-1:0]      di
);
    logic [W-1:0] rf [N_REGS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N_REGS; i++) begin
                rf[i] <= (i == int'(RI_SP)) ? SP_INIT : '0;
            end
        end else if (we) begin
            rf[widx] <= wdata;
        end
    end

    always_comb begin
        rdata = rf[ridx];
        ax    = rf[RI_AX];
        sp    = rf[RI_SP];
        di    = rf[RI_DI];
    end
endmodule

// File: rtl/useq_stack_seq.sv
`timescale 1ns/1ps
module useq_stack_seq
    import useq_pkg::*;
#(
    parameter logic [WORD_W-1:0] RESET_PC = 16'hFFF0,
    parameter logic [WORD_W-1:0] SP_INIT  = 16'h0400,
    parameter logic [WORD_W-1:0] VEC_BASE = 16'h0000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              issue_valid,
    input  logic [2:0]        issue_op,
    input  logic [RIDX_W-1:0] issue_reg,
    input  logic [WORD_W-1:0] issue_imm,
    input  logic              issue_wide,
    output logic              busy,
    output logic [WORD_W-1:0] pc_out,
    output logic [WORD_W-1:0] sp_out,
    output logic [WORD_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    output logic              mem_we,
    output logic              mem_re,
    output logic              mem_wide,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              mem_ready
);
    localparam int unsigned W = WORD_W;

    logic [UA_W-1:0]   upc;
    uins_t             ui;
    logic [W-1:0]      pc_q, imm_q, param_q, rlat_q;
    logic [RIDX_W-1:0] reg_q;
    logic              wide_q;
    logic              idle, is_rd, stall;
    logic [W-1:0]      opa, opb, alu_y;
    logic [W-1:0]      ax, sp, di, reg_rd;
    logic              rf_we;
    logic [RIDX_W-1:0] rf_widx;

    useq_rom u_rom (.addr(upc), .word(ui));

    useq_alu #(.W(W)) u_alu (.a(opa), .b(opb), .op(ui.op), .y(alu_y));

    useq_regfile #(.W(W), .SP_INIT(SP_INIT)) u_rf (
        .clk(clk), .rst(rst), .we(rf_we), .widx(rf_widx), .wdata(alu_y),
        .ridx(reg_q), .rdata(reg_rd), .ax(ax), .sp(sp), .di(di)
    );

    always_comb begin
        idle  = (upc == '0);
        is_rd = (ui.nxs == NX_RD_REG) || (ui.nxs == NX_RD_ALU);
        stall = is_rd && !mem_ready;

        case (ui.a)
            A_PARAM: opa = param_q;
            A_SP:    opa = sp;
            A_DI:    opa = di;
            A_PC:    opa = pc_q;
            default: opa = '0;
        endcase

        case (ui.b)
            B_TWO:   opb = W'(2);
            B_PC:    opb = pc_q;
            B_REG:   opb = reg_rd;
            B_AX:    opb = ax;
            B_RDATA: opb = mem_rdata;
            B_LATCH: opb = rlat_q;
            B_BASE:  opb = VEC_BASE;
            default: opb = '0;
        endcase

        rf_we = !stall && (ui.dst == D_REG || ui.dst == D_SP || ui.dst == D_DI);
        case (ui.dst)
            D_SP:    rf_widx = RI_SP;
            D_DI:    rf_widx = RI_DI;
            default: rf_widx = reg_q;
        endcase

        mem_addr  = ui.mas ? alu_y : ((ui.mreg == M_DI) ? di : sp);
        mem_wdata = alu_y;
        mem_we    = (ui.dst == D_MEM);
        mem_re    = is_rd;
        mem_wide  = ui.wbo[0] ? ui.wbo[1] : wide_q;

        busy   = !idle;
        pc_out = pc_q;
        sp_out = sp;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            upc     <= '0;
            pc_q    <= RESET_PC;
            imm_q   <= '0;
            param_q <= '0;
            rlat_q  <= '0;
            reg_q   <= '0;
            wide_q  <= 1'b0;
        end else begin
            if (idle) begin
                if (issue_valid) begin
                    upc    <= entry_of(iop_e'(issue_op));
                    imm_q  <= issue_imm;
                    reg_q  <= issue_reg;
                    wide_q <= issue_wide;
                end
            end else if (!stall) begin
                upc <= ui.nxt;
            end

            if (!stall && ui.dst == D_PC) pc_q <= alu_y;

            if (!stall) begin
                if (ui.dst == D_PARAM)      param_q <= alu_y;
                else if (ui.nxs == NX_LD16) param_q <= imm_q;
                else if (ui.nxs == NX_LD8)  param_q <= {8'h00, imm_q[7:0]};
            end

            if (is_rd && mem_ready) rlat_q <= mem_rdata;
        end
    end

    // R2: nothing touches memory while no microprogram runs
    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        (upc == '0) |-> (!mem_we && !mem_re));

    // R9: a pending read freezes PC, SP and the micro-step
    a_r9_stall_hold: assert property (@(posedge clk) disable iff (rst)
        (mem_re && !mem_ready) |=> ($stable(pc_q) && $stable(upc) && $stable(sp)));

    // R3: CALL stores at the already decremented stack pointer on its second step
    a_r3_call_store: assert property (@(posedge clk) disable iff (rst)
        (idle && issue_valid && issue_op == 3'd1) |=> ##1 (mem_we && mem_addr == sp_out));

    // R7: STOS first step stores AX as a word
    a_r7_stos_word: assert property (@(posedge clk) disable iff (rst)
        (idle && issue_valid && issue_op == 3'd3) |=> (mem_we && mem_wide && mem_wdata == ax));

    // R5: PUSH lowers the stack pointer by two after its first step
    a_r5_push_sp: assert property (@(posedge clk) disable iff (rst)
        (idle && issue_valid && issue_op == 3'd4) |=> ##1 (sp_out == $past(sp_out, 2) - 16'd2));

endmodule

// File: tb/sim_useq_stack_seq.sv
`timescale 1ns/1ps
module sim_useq_stack_seq;

    localparam logic [15:0] VEC_BASE = 16'h0000;

    typedef struct packed {
        logic [2:0]  op;
        logic [2:0]  rsel;
        logic [15:0] imm;
        logic        wide;
        logic [15:0] rd;
        logic [3:0]  lat;
        logic        noise;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{3'd5, 3'd0, 16'h0000, 1'b1, 16'h1234, 4'd0, 1'b0}, // POP AX
        '{3'd5, 3'd7, 16'h0000, 1'b0, 16'h0200, 4'd2, 1'b0}, // POP DI, slow
        '{3'd3, 3'd0, 16'h0000, 1'b0, 16'h0000, 4'd0, 1'b0}, // STOS, narrow bit
        '{3'd3, 3'd0, 16'h0000, 1'b1, 16'h0000, 4'd0, 1'b0}, // STOS
        '{3'd4, 3'd0, 16'h0000, 1'b1, 16'h0000, 4'd0, 1'b0}, // PUSH AX
        '{3'd5, 3'd3, 16'h0000, 1'b0, 16'hBEEF, 4'd1, 1'b0}, // POP BX
        '{3'd4, 3'd3, 16'h0000, 1'b0, 16'h0000, 4'd0, 1'b0}, // PUSH BX, narrow
        '{3'd1, 3'd0, 16'h0010, 1'b1, 16'h0000, 4'd0, 1'b0}, // CALL +0x10
        '{3'd2, 3'd0, 16'h0000, 1'b1, 16'h2000, 4'd3, 1'b1}, // RET with issue noise
        '{3'd6, 3'd0, 16'hAB21, 1'b1, 16'h0100, 4'd1, 1'b0}, // INT 0x21
        '{3'd1, 3'd0, 16'hFFFE, 1'b1, 16'h0000, 4'd0, 1'b0}, // CALL -2
        '{3'd4, 3'd4, 16'h0000, 1'b1, 16'h0000, 4'd0, 1'b0}, // PUSH SP
        '{3'd6, 3'd0, 16'h00FF, 1'b0, 16'h5555, 4'd0, 1'b0}, // INT 0xFF
        '{3'd5, 3'd2, 16'h0000, 1'b1, 16'h7777, 4'd4, 1'b1}, // POP DX with noise
        '{3'd5, 3'd4, 16'h0000, 1'b1, 16'h0300, 4'd0, 1'b0}  // POP SP
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        issue_valid = 1'b0;
    logic [2:0]  issue_op = 3'd0;
    logic [2:0]  issue_reg = 3'd0;
    logic [15:0] issue_imm = 16'h0;
    logic        issue_wide = 1'b0;
    logic        busy;
    logic [15:0] pc_out, sp_out, mem_addr, mem_wdata;
    logic        mem_we, mem_re, mem_wide;
    logic [15:0] mem_rdata = 16'h0;
    logic        mem_ready = 1'b0;

    int checks = 0;
    int failures = 0;

    logic [15:0] m_pc;
    logic [15:0] m_r [8];

    always #2.5 clk = ~clk;

    useq_stack_seq #(.VEC_BASE(VEC_BASE)) u0 (
        .clk(clk), .rst(rst), .issue_valid(issue_valid), .issue_op(issue_op),
        .issue_reg(issue_reg), .issue_imm(issue_imm), .issue_wide(issue_wide),
        .busy(busy), .pc_out(pc_out), .sp_out(sp_out), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_re(mem_re), .mem_wide(mem_wide),
        .mem_rdata(mem_rdata), .mem_ready(mem_ready)
    );

    task automatic chk(input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic run_vec(input vec_t v);
        string       tag;
        logic        e_w = 1'b0, e_r = 1'b0, e_wide;
        logic [15:0] e_wa = '0, e_wd = '0, e_ra = '0;
        int          e_cyc = 0;
        logic        got_w = 1'b0, got_r = 1'b0, w_wide = 1'b0, rd_moved = 1'b0;
        logic [15:0] w_a = '0, w_d = '0, r_a = '0;
        int          cyc = 0, waited = 0;

        e_wide = v.wide;
        case (v.op)
            3'd1: begin tag = "R3"; m_r[4] = m_r[4] - 16'd2; e_w = 1'b1;
                        e_wa = m_r[4]; e_wd = m_pc; m_pc = m_pc + v.imm; e_cyc = 3; end
            3'd2: begin tag = "R4"; e_r = 1'b1; e_ra = m_r[4]; m_pc = v.rd;
                        m_r[4] = m_r[4] + 16'd2; e_cyc = 2 + int'(v.lat); end
            3'd3: begin tag = "R7"; e_w = 1'b1; e_wa = m_r[7]; e_wd = m_r[0]; e_wide = 1'b1;
                        m_r[7] = m_r[7] + 16'd2; e_cyc = 2; end
            3'd4: begin tag = "R5"; m_r[4] = m_r[4] - 16'd2; e_w = 1'b1;
                        e_wa = m_r[4]; e_wd = m_r[v.rsel]; e_cyc = 2; end
            3'd5: begin tag = "R6"; e_r = 1'b1; e_ra = m_r[4]; m_r[v.rsel] = v.rd;
                        m_r[4] = m_r[4] + 16'd2; e_cyc = 2 + int'(v.lat); end
            default: begin tag = "R8"; m_r[4] = m_r[4] - 16'd2; e_w = 1'b1;
                        e_wa = m_r[4]; e_wd = m_pc; e_r = 1'b1;
                        e_ra = VEC_BASE + {7'b0, v.imm[7:0], 1'b0};
                        m_pc = v.rd; e_cyc = 5 + int'(v.lat); end
        endcase

        @(negedge clk);
        issue_op = v.op; issue_reg = v.rsel; issue_imm = v.imm;
        issue_wide = v.wide; issue_valid = 1'b1;
        @(negedge clk);
        issue_valid = 1'b0;
        while (busy && cyc < 40) begin
            if (mem_re) begin
                if (!got_r) begin got_r = 1'b1; r_a = mem_addr; end
                else if (mem_addr !== r_a) rd_moved = 1'b1;
                if (waited < int'(v.lat)) begin
                    waited++;
                    mem_ready = 1'b0;
                    if (v.noise) begin issue_valid = 1'b1; issue_op = 3'd1; end
                end else begin
                    mem_ready = 1'b1;
                    mem_rdata = v.rd;
                end
            end
            if (mem_we) begin
                got_w = 1'b1; w_a = mem_addr; w_d = mem_wdata; w_wide = mem_wide;
            end
            cyc++;
            @(negedge clk);
            mem_ready = 1'b0;
            issue_valid = 1'b0;
        end

        chk(tag, "step count", 16'(cyc), 16'(e_cyc));
        chk(tag, "pc", pc_out, m_pc);
        chk(tag, "sp", sp_out, m_r[4]);
        chk(tag, "write seen", {15'b0, got_w}, {15'b0, e_w});
        chk(tag, "read seen", {15'b0, got_r}, {15'b0, e_r});
        if (e_w) begin
            chk(tag, "write addr", w_a, e_wa);
            chk(tag, "write data", w_d, e_wd);
            chk((v.op == 3'd3) ? "R7" : "R10", "mem_wide", {15'b0, w_wide}, {15'b0, e_wide});
        end
        if (e_r) begin
            chk(tag, "read addr", r_a, e_ra);
            chk("R9", "read addr stable in stall", {15'b0, rd_moved}, 16'h0);
        end
        if (v.noise) begin
            @(negedge clk);
            chk("R2", "no issue taken during stall", {15'b0, busy}, 16'h0);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        m_pc = 16'hFFF0;
        for (int i = 0; i < 8; i++) m_r[i] = 16'h0;
        m_r[4] = 16'h0400;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk("R1", "pc", pc_out, 16'hFFF0);
        chk("R1", "sp", sp_out, 16'h0400);
        chk("R1", "busy", {15'b0, busy}, 16'h0);
        chk("R1", "strobes", {14'b0, mem_we, mem_re}, 16'h0);

        // R2: codes 0 and 7 are not accepted
        for (int k = 0; k < 2; k++) begin
            issue_op = (k == 0) ? 3'd0 : 3'd7;
            issue_valid = 1'b1;
            @(negedge clk);
            issue_valid = 1'b0;
            chk("R2", "busy after bad code", {15'b0, busy}, 16'h0);
            chk("R2", "pc after bad code", pc_out, m_pc);
            chk("R2", "sp after bad code", sp_out, m_r[4]);
        end

        for (int n = 0; n < NV; n++) run_vec(VECS[n]);

        // R6 / R5: DX loaded by the noisy POP comes back through PUSH
        run_vec('{3'd4, 3'd2, 16'h0000, 1'b0, 16'h0000, 4'd0, 1'b0});

        // R1: synchronous reset mid-sequence returns to the reset state
        @(negedge clk);
        issue_op = 3'd1; issue_imm = 16'h0040; issue_valid = 1'b1;
        @(negedge clk);
        issue_valid = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R1", "pc after mid reset", pc_out, 16'hFFF0);
        chk("R1", "sp after mid reset", sp_out, 16'h0400);
        chk("R1", "busy after mid reset", {15'b0, busy}, 16'h0);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule